// File: doc/BRIEF.md
# BCD Calendar Clock with Field Alarms

This block keeps wall-clock time as six BCD counters: seconds, minutes, hours, day of month, month and two-digit year. A free-running prescaler counts bus clock cycles. Each time it reaches a programmable terminal count it produces a one-cycle tick, and the seconds field advances on that tick. Each wrap of a field carries into the field above it. Day-of-month limits come from a fixed month-length table in which February always has 28 days.

Software reaches the block through a flat word-addressed register port. Writes are single-cycle and reads are combinational. The port gives access to the six counters, a control word, the prescaler terminal count, one BCD alarm value per field, an alarm enable mask, a read-only alarm status word and a write-one-to-clear word.

Each field has its own comparator. At a tick, the comparator sets a sticky status bit if the field's current value equals its alarm value. A single interrupt line is raised while any enabled status bit is set. The control word can hold the whole calendar at its reset values. It can also make any field above seconds count directly on each tick, so that the upper fields can be exercised quickly.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the counters read second 0x00, minute 0x00, hour 0x00, day 0x01, month 0x01 and year 0x00. The control word reads 0x80. The divisor, every alarm register, the enable word and the status word read 0, and `irq` is low.
- R2: In the control word (address 6), bits 0 and 6 ignore writes and always read 0. Bits 1 to 5 and bit 7 read back the value last written.
- R3: With divisor value D (address 7), a tick occurs once every D+1 clock cycles, measured from release of the hold bit. The seconds field advances by one on each tick.
- R4: While control bit 7 is 1, every counter is forced to its R1 value, no tick occurs, and writes to the counter addresses 0 to 5 are ignored.
- R5: Counters count in BCD. Seconds and minutes run 00 to 59, hours 00 to 23, month 01 to 12 and year 00 to 99. Each field wraps to its lowest value, and each wrap advances the next field up in the order second, minute, hour, day, month, year, all within one tick.
- R6: The day wraps to 01 after 28 in month 02, after 30 in months 04, 06, 09 and 11, and after 31 in every other month.
- R7: While the hold bit is 0, a write to addresses 0 to 5 (second to year) loads that counter. A write to the status word (address 15) has no effect. In the enable word (address 14), bits 6 and 7 read 0.
- R8: Control bits 1 to 5 put minute, hour, day, month and year, respectively, into test mode. A field in test mode advances on every tick instead of on the carry from below. It still wraps at its normal limit and still carries upward.
- R9: Addresses 8 to 13 hold the BCD alarm values for second to year. Status bit i (bit 0 second up to bit 5 year, address 15) becomes 1 at a tick in which field i holds its alarm value, and stays 1 across later ticks.
- R10: Writing the clear word (address 16) clears every status bit written as 1. Bits written as 0 leave their status unchanged.
- R11: `irq` is 1 exactly when some status bit and the enable bit at the same position (address 14, same bit order as status) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the prescaler clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address of the register accessed |
| wrEn | input | 1 | Write strobe, captured at the rising clock edge |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | Alarm interrupt: OR of enabled status bits |

## Verification
The bench gives the prescaler an off-by-one trap: after release with divisor 9, exactly ten seconds must appear after 100 cycles. A design that ticks every D cycles reads 0x11 instead. Full-chain rollover from 23:59:59 on 31 December, together with the February, April and 31-day month boundaries, exposes a wrong length table or a broken carry. Such a design would show a day of 29 or 31 where 01 is expected, or a month that fails to advance. Test mode is checked by confirming that minute runs from the tick and still carries into hour. Alarm status is shown to survive later ticks, to ignore zero bits in the clear word and to reach `irq` only through its own enable bit. A design that compared against the updated value, or cleared on any write, would leave a status bit wrong.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FIELDS      = 6;
  localparam int TEST_FIELDS = FIELDS - 1;

  // Register word addresses
  localparam int ADR_FIELD0  = 0;   // second .. year at 0..5
  localparam int ADR_CTRL    = 6;
  localparam int ADR_DIV     = 7;
  localparam int ADR_ALARM0  = 8;   // second .. year alarms at 8..13
  localparam int ADR_INT_EN  = 14;
  localparam int ADR_INT_ST  = 15;
  localparam int ADR_INT_CLR = 16;

  localparam logic [7:0] FIELD_MIN [FIELDS] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
  localparam logic [7:0] FIELD_MAX [FIELDS] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99};

  typedef struct packed {
    logic [FIELDS-1:0]      loadMask;
    logic [7:0]             loadValue;
    logic                   holdAll;
    logic [TEST_FIELDS-1:0] testMask;
  } cal_strobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] monthLen(input logic [7:0] m);
    case (m)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cal_strobe_t             strb,
  input  logic [DIV_W-1:0]        divisor,
  output logic                    tick,
  output logic [FIELDS-1:0][7:0]  fieldVal
);
  logic [DIV_W-1:0] prescale;

  // Tick when the prescaler has reached the terminal count
  always_comb tick = !strb.holdAll && (prescale >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     prescale <= '0;
    else if (strb.holdAll || tick) prescale <= '0;
    else                           prescale <= prescale + 1'b1;
  end

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_field
    logic [7:0] fieldQ;
    logic [7:0] limitHi;
    logic       stepEn;
    logic       atTop;
    logic       carryOut;

    if (gi == 3) begin : g_dayLimit
      assign limitHi = monthLen(fieldVal[4]);
    end else begin : g_fixLimit
      assign limitHi = FIELD_MAX[gi];
    end

    if (gi == 0) begin : g_base
      assign stepEn = tick;
    end else begin : g_chain
      assign stepEn = tick & (strb.testMask[gi-1] | g_field[gi-1].carryOut);
    end

    assign atTop    = fieldQ >= limitHi;
    assign carryOut = stepEn & atTop;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  fieldQ <= FIELD_MIN[gi];
      else if (strb.holdAll)      fieldQ <= FIELD_MIN[gi];
      else if (strb.loadMask[gi]) fieldQ <= strb.loadValue;
      else if (stepEn)            fieldQ <= atTop ? FIELD_MIN[gi] : bcdInc(fieldQ);
    end

    assign fieldVal[gi] = fieldQ;
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   irq,
  input  logic                   tick,
  input  logic [FIELDS-1:0][7:0] fieldVal,
  output cal_strobe_t            strb,
  output logic [DIV_W-1:0]       divisor,
  output logic [FIELDS-1:0]      statusOut
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(ADR_DIV);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_INT_EN);
  localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(ADR_INT_ST);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADR_INT_CLR);

  logic                   ctrlHold;
  logic [TEST_FIELDS-1:0] ctrlTest;
  logic [DIV_W-1:0]       divQ;
  logic [FIELDS-1:0]      intEn;
  logic [FIELDS-1:0]      statusQ;
  logic [FIELDS-1:0][7:0] alarmQ;
  logic [FIELDS-1:0]      hitMask;
  logic [FIELDS-1:0]      clrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlHold <= 1'b1;
      ctrlTest <= '0;
      divQ     <= '0;
      intEn    <= '0;
    end else if (wrEn) begin
      if (addr == A_CTRL) begin
        ctrlHold <= wrData[7];
        ctrlTest <= wrData[5:1];
      end
      if (addr == A_DIV) divQ  <= wrData[DIV_W-1:0];
      if (addr == A_EN)  intEn <= wrData[FIELDS-1:0];
    end
  end

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_alarm
    localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(ADR_ALARM0 + gi);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      alarmQ[gi] <= '0;
      else if (wrEn && addr == A_ALM) alarmQ[gi] <= wrData[7:0];
    end
    assign hitMask[gi] = tick && (fieldVal[gi] == alarmQ[gi]);
  end

  assign clrMask = (wrEn && addr == A_CLR) ? wrData[FIELDS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | hitMask;
  end

  always_comb begin
    strb.holdAll   = ctrlHold;
    strb.testMask  = ctrlTest;
    strb.loadValue = wrData[7:0];
    for (int i = 0; i < FIELDS; i++)
      strb.loadMask[i] = wrEn && !ctrlHold && (addr == ADDR_W'(ADR_FIELD0 + i));
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < FIELDS; i++) begin
      if (addr == ADDR_W'(ADR_FIELD0 + i)) rdData = DATA_W'(fieldVal[i]);
      if (addr == ADDR_W'(ADR_ALARM0 + i)) rdData = DATA_W'(alarmQ[i]);
    end
    if (addr == A_CTRL) rdData = DATA_W'({ctrlHold, 1'b0, ctrlTest, 1'b0});
    if (addr == A_DIV)  rdData = DATA_W'(divQ);
    if (addr == A_EN)   rdData = DATA_W'(intEn);
    if (addr == A_ST)   rdData = DATA_W'(statusQ);
  end

  assign irq       = |(statusQ & intEn);
  assign divisor   = divQ;
  assign statusOut = statusQ;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  cal_strobe_t            strb;
  logic [DIV_W-1:0]       divisor;
  logic                   tick;
  logic [FIELDS-1:0][7:0] fieldVal;
  logic [FIELDS-1:0]      statusQ;
  logic                   holdAll;
  logic                   anyLoad;
  logic [7:0]             secVal;

  cal_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irq(irq), .tick(tick), .fieldVal(fieldVal),
    .strb(strb), .divisor(divisor), .statusOut(statusQ)
  );

  cal_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .divisor(divisor),
    .tick(tick), .fieldVal(fieldVal)
  );

  assign holdAll = strb.holdAll;
  assign anyLoad = |strb.loadMask;
  assign secVal  = fieldVal[0];
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input logic              holdAll,
  input logic              tick,
  input logic              anyLoad,
  input logic [7:0]        secVal,
  input logic [FIELDS-1:0] statusQ
);
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(ADR_CTRL)) |-> (rdData[0] == 1'b0 && rdData[6] == 1'b0)); // R2

  AST_SEC_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tick) && !$past(anyLoad) && !$past(holdAll)) |-> $stable(secVal)); // R3

  AST_HOLD_CLEARS_SEC: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdAll) |-> (secVal == 8'h00)); // R4

  AST_STATUS_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusQ) & ~statusQ)) |-> $past(wrEn && addr == ADDR_W'(ADR_INT_CLR))); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != '0)); // R11
endmodule

bind bcd_calendar cal_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdData(rdData),
  .irq(irq), .holdAll(holdAll), .tick(tick), .anyLoad(anyLoad),
  .secVal(secVal), .statusQ(statusQ)
);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              irq;

  int checks = 0;
  int errors = 0;

  bcd_calendar #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #5 clk = ~clk;

  localparam int SEC = 0, MIN = 1, HOUR = 2, DAY = 3, MON = 4, YEAR = 5;
  localparam int CTRL = 6, DIVR = 7, ALM0 = 8, INTEN = 14, INTST = 15, INTCLR = 16;

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a[ADDR_W-1:0];
    wrData = d;
    wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input int a, input logic [DATA_W-1:0] exp);
    addr = a[ADDR_W-1:0];
    #1 check(req, rdData, exp);
  endtask

  // Exactly n ticks: divisor 0 for n cycles, then frozen again
  task automatic stepTicks(input int n);
    wr(DIVR, 16'h0000);
    repeat (n - 1) @(posedge clk);
    wr(DIVR, 16'hFFFF);
  endtask

  task automatic loadTime(input logic [7:0] yr, mo, dy, hr, mi, se);
    wr(YEAR, yr); wr(MON, mo); wr(DAY, dy); wr(HOUR, hr); wr(MIN, mi); wr(SEC, se);
  endtask

  task automatic testReset();
    expectReg("R1 second", SEC, 16'h00);
    expectReg("R1 minute", MIN, 16'h00);
    expectReg("R1 hour", HOUR, 16'h00);
    expectReg("R1 day", DAY, 16'h01);
    expectReg("R1 month", MON, 16'h01);
    expectReg("R1 year", YEAR, 16'h00);
    expectReg("R1 control", CTRL, 16'h80);
    expectReg("R1 divisor", DIVR, 16'h0000);
    expectReg("R1 alarm", ALM0 + 2, 16'h00);
    expectReg("R1 enable", INTEN, 16'h00);
    expectReg("R1 status", INTST, 16'h00);
    check("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic testReserved();
    wr(CTRL, 16'h00FF);
    expectReg("R2 control all ones", CTRL, 16'hBE);
    wr(CTRL, 16'h00C1);
    expectReg("R2 reserved only", CTRL, 16'h80);
    wr(INTEN, 16'h00FF);
    expectReg("R7 enable upper bits", INTEN, 16'h3F);
    wr(INTEN, 16'h0000);
  endtask

  task automatic testHold();
    wr(DIVR, 16'h0000);
    wr(SEC, 16'h0025);
    expectReg("R4 load ignored", SEC, 16'h00);
    repeat (10) @(posedge clk);
    expectReg("R4 no counting", SEC, 16'h00);
  endtask

  task automatic testDivisor();
    wr(DIVR, 16'h0009);
    wr(CTRL, 16'h0000);
    repeat (100) @(posedge clk);
    expectReg("R3 ten ticks", SEC, 16'h10);
    wr(DIVR, 16'hFFFF);
    repeat (20) @(posedge clk);
    expectReg("R3 frozen", SEC, 16'h10);
  endtask

  task automatic testCarry();
    loadTime(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    expectReg("R7 load second", SEC, 16'h59);
    expectReg("R7 load month", MON, 16'h12);
    stepTicks(1);
    expectReg("R5 second wrap", SEC, 16'h00);
    expectReg("R5 minute wrap", MIN, 16'h00);
    expectReg("R5 hour wrap", HOUR, 16'h00);
    expectReg("R5 day wrap", DAY, 16'h01);
    expectReg("R5 month wrap", MON, 16'h01);
    expectReg("R5 year wrap", YEAR, 16'h00);
    loadTime(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h08);
    stepTicks(2);
    expectReg("R5 bcd digit", SEC, 16'h10);
  endtask

  task automatic rollDay(input string req, input logic [7:0] mo, dy, expDay, expMon);
    loadTime(8'h05, mo, dy, 8'h23, 8'h59, 8'h59);
    stepTicks(1);
    expectReg(req, DAY, {8'h00, expDay});
    expectReg(req, MON, {8'h00, expMon});
  endtask

  task automatic testMonths();
    rollDay("R6 february", 8'h02, 8'h28, 8'h01, 8'h03);
    rollDay("R6 april end", 8'h04, 8'h30, 8'h01, 8'h05);
    rollDay("R6 april mid", 8'h04, 8'h29, 8'h30, 8'h04);
    rollDay("R6 november", 8'h11, 8'h30, 8'h01, 8'h12);
    rollDay("R6 january", 8'h01, 8'h30, 8'h31, 8'h01);
  endtask

  task automatic testMode();
    wr(CTRL, 16'h0002);
    loadTime(8'h10, 8'h07, 8'h15, 8'h05, 8'h58, 8'h10);
    stepTicks(3);
    expectReg("R8 minute on tick", MIN, 16'h01);
    expectReg("R8 minute carry to hour", HOUR, 16'h06);
    expectReg("R8 second normal", SEC, 16'h13);
    wr(CTRL, 16'h0020);
    wr(YEAR, 16'h0098);
    stepTicks(2);
    expectReg("R8 year wrap", YEAR, 16'h00);
    expectReg("R8 month untouched", MON, 16'h07);
    wr(CTRL, 16'h0000);
  endtask

  task automatic testAlarms();
    for (int i = 0; i < 6; i++) wr(ALM0 + i, 16'h00FF);
    wr(INTEN, 16'h0000);
    wr(INTCLR, 16'h003F);
    expectReg("R10 clear all", INTST, 16'h00);
    wr(ALM0 + SEC, 16'h0005);
    expectReg("R9 alarm readback", ALM0 + SEC, 16'h05);
    wr(SEC, 16'h0003);
    stepTicks(3);
    expectReg("R9 second match", INTST, 16'h01);
    check("R11 disabled irq", {15'b0, irq}, 16'h0);
    wr(INTEN, 16'h0001);
    #1 check("R11 enabled irq", {15'b0, irq}, 16'h1);
    stepTicks(4);
    expectReg("R9 sticky", INTST, 16'h01);
    wr(INTST, 16'h0000);
    expectReg("R7 status read only", INTST, 16'h01);
    wr(INTCLR, 16'h003E);
    expectReg("R10 zero bits ignored", INTST, 16'h01);
    wr(INTCLR, 16'h0001);
    expectReg("R10 clear one", INTST, 16'h00);
    #1 check("R11 irq drops", {15'b0, irq}, 16'h0);
    wr(ALM0 + HOUR, 16'h0007);
    wr(HOUR, 16'h0007);
    stepTicks(1);
    expectReg("R9 hour match", INTST, 16'h04);
    #1 check("R11 other enable", {15'b0, irq}, 16'h0);
    wr(INTEN, 16'h0004);
    #1 check("R11 hour enable", {15'b0, irq}, 16'h1);
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testReserved();
    testHold();
    testDivisor();
    testCarry();
    testMonths();
    testMode();
    testAlarms();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule